// File: doc/BRIEF.md
# Receive Polarity Detector and Corrector

This block watches a twisted-pair receive channel for signs that its two wires have been swapped. An analog front end reports each link pulse and each end-of-packet pulse as one single-cycle strobe, on one of two lines: one line for a pulse of the expected sign and one for a pulse of the opposite sign. The block keeps two independent runs of consecutive wrong-sign events. One run counts link pulses and the other counts packet endings, and each run has its own threshold. When either run reaches its threshold, a sticky bad-polarity flag is set.

While the flag is set, the block inverts the received data bit on its way to the decoder, so reception stays correct without any change to the wiring. The flag also drives a status LED. The flag clears only when the block is reset or when the link is reported as failed.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset `pol_bad` is 0 and `rx_fixed` follows `rx_raw` unchanged.
- R2: `pol_bad` rises on the clock edge that samples the 7th consecutive `lp_inv` strobe (LINK_RUN = 7). Six such strobes leave it at 0.
- R3: `pol_bad` rises on the clock edge that samples the 3rd consecutive `eop_inv` strobe (EOP_RUN = 3). Two such strobes leave it at 0.
- R4: An `lp_ok` strobe empties the link-pulse run, and so does `lp_ok` together with `lp_inv` in the same cycle (the correct sign wins). Counting then restarts from zero.
- R5: An `eop_ok` strobe empties the packet-ending run. Counting then restarts from zero.
- R6: The two runs are independent. Link-pulse strobes of either sign neither advance nor empty the packet-ending run, and packet-ending strobes neither advance nor empty the link-pulse run.
- R7: Once set, `pol_bad` stays at 1 through any number of correct-sign strobes, until `link_fail` or reset.
- R8: `rx_fixed` equals `rx_raw` when `pol_bad` is 0 and equals its inverse when `pol_bad` is 1, in the same cycle with no register in the path.
- R9: A `link_fail` strobe clears `pol_bad` on the next edge. It overrides a set request in the same cycle, and it leaves both runs as they were.
- R10: Each run saturates at its threshold and never wraps. After any number of wrong-sign strobes of one kind, followed by `link_fail`, a single further wrong-sign strobe of that kind sets `pol_bad` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_ok | input | 1 | Link pulse of the expected sign seen this cycle |
| lp_inv | input | 1 | Link pulse of the opposite sign seen this cycle |
| eop_ok | input | 1 | End-of-packet pulse of the expected sign seen this cycle |
| eop_inv | input | 1 | End-of-packet pulse of the opposite sign seen this cycle |
| link_fail | input | 1 | Link integrity lost; clears the polarity flag |
| rx_raw | input | 1 | Received data bit from the front end |
| rx_fixed | output | 1 | Received data bit after polarity correction |
| pol_bad | output | 1 | Latched bad-polarity status, drives the LED |

## Verification
The bench sweeps unbroken runs of each wrong-sign event, from zero up to well past its threshold. This finds the exact strobe at which the flag rises and shows that the two thresholds are separate. A second sweep moves a single correct-sign event to every position inside a run, so that a run that restarts is told apart from a run that merely pauses. Mixed sequences, with link-pulse strobes placed inside a packet-ending run and the other way round, show that the runs are independent. Long runs followed by a link failure tell a saturating counter apart from a wrapping one. A failure raised in the same cycle as the final strobe shows that clearing takes precedence over setting.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;

  // Next value of a consecutive-event run: the correct sign restarts it,
  // the wrong sign advances it up to the limit and holds there.
  function automatic int run_next(input int cur, input int limit,
                                  input logic good, input logic wrong);
    int r;
    if (good)
      r = 0;
    else if (wrong)
      r = (cur >= limit) ? limit : cur + 1;
    else
      r = cur;
    return r;
  endfunction

  // Bit width needed to hold values 0..limit.
  function automatic int run_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pol_run_counter.sv
module pol_run_counter #(
  parameter int LIMIT = 7,
  parameter int CW    = rx_polarity_pkg::run_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          good_evt,
  input  logic          wrong_evt,
  output logic [CW-1:0] run,
  output logic          hit
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] run_nx;

  always_comb begin
    run_nx = CW'(rx_polarity_pkg::run_next(int'(run), LIMIT, good_evt, wrong_evt));
    hit    = wrong_evt && !good_evt && (run_nx == LIM_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else
      run <= run_nx;
  end
endmodule

// File: rtl/pol_flag_latch.sv
module pol_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (clr_req)
      flag <= 1'b0;
    else if (set_req)
      flag <= 1'b1;
  end
endmodule

// File: rtl/pol_data_fix.sv
module pol_data_fix (
  input  logic din,
  input  logic invert,
  output logic dout
);
  always_comb dout = invert ? ~din : din;
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix #(
  parameter int LINK_RUN = 7,
  parameter int EOP_RUN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_ok,
  input  logic lp_inv,
  input  logic eop_ok,
  input  logic eop_inv,
  input  logic link_fail,
  input  logic rx_raw,
  output logic rx_fixed,
  output logic pol_bad
);
  localparam int LW = rx_polarity_pkg::run_width(LINK_RUN);
  localparam int EW = rx_polarity_pkg::run_width(EOP_RUN);

  logic [LW-1:0] lp_run;
  logic [EW-1:0] eop_run;
  logic          lp_hit;
  logic          eop_hit;
  logic          set_req;

  pol_run_counter #(.LIMIT(LINK_RUN), .CW(LW)) u_lp_run (
    .clk(clk), .rst_n(rst_n), .good_evt(lp_ok), .wrong_evt(lp_inv),
    .run(lp_run), .hit(lp_hit)
  );

  pol_run_counter #(.LIMIT(EOP_RUN), .CW(EW)) u_eop_run (
    .clk(clk), .rst_n(rst_n), .good_evt(eop_ok), .wrong_evt(eop_inv),
    .run(eop_run), .hit(eop_hit)
  );

  assign set_req = lp_hit | eop_hit;

  pol_flag_latch u_flag (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(link_fail),
    .flag(pol_bad)
  );

  pol_data_fix u_fix (
    .din(rx_raw), .invert(pol_bad), .dout(rx_fixed)
  );
endmodule

// File: rtl/rx_polarity_fix_chk.sv
module rx_polarity_fix_chk #(
  parameter int LINK_RUN = 7,
  parameter int EOP_RUN  = 3,
  parameter int LW       = 3,
  parameter int EW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lp_ok,
  input logic          eop_ok,
  input logic          link_fail,
  input logic          rx_raw,
  input logic          rx_fixed,
  input logic          pol_bad,
  input logic          lp_hit,
  input logic          eop_hit,
  input logic [LW-1:0] lp_run,
  input logic [EW-1:0] eop_run
);
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_bad) |-> $past(lp_hit || eop_hit));

  assert_lp_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ok |=> (lp_run == '0));

  assert_eop_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_ok |=> (eop_run == '0));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_bad && !link_fail) |=> pol_bad);

  assert_flip_only_when_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fixed != rx_raw) |-> pol_bad);

  assert_fail_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !pol_bad);

  assert_lp_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lp_run) <= LINK_RUN);

  assert_eop_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(eop_run) <= EOP_RUN);
endmodule

bind rx_polarity_fix rx_polarity_fix_chk #(
  .LINK_RUN(LINK_RUN), .EOP_RUN(EOP_RUN), .LW(LW), .EW(EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_ok(lp_ok), .eop_ok(eop_ok),
  .link_fail(link_fail), .rx_raw(rx_raw), .rx_fixed(rx_fixed),
  .pol_bad(pol_bad), .lp_hit(lp_hit), .eop_hit(eop_hit),
  .lp_run(lp_run), .eop_run(eop_run)
);

// File: tb/test_rx_polarity_fix.sv
module test_rx_polarity_fix;
  localparam int PERIOD   = 10;
  localparam int LINK_RUN = 7;
  localparam int EOP_RUN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_ok = 1'b0, lp_inv = 1'b0, eop_ok = 1'b0, eop_inv = 1'b0;
  logic link_fail = 1'b0, rx_raw = 1'b0;
  logic rx_fixed, pol_bad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rx_polarity_fix #(.LINK_RUN(LINK_RUN), .EOP_RUN(EOP_RUN)) i_rx_polarity_fix (
    .clk(clk), .rst_n(rst_n), .lp_ok(lp_ok), .lp_inv(lp_inv),
    .eop_ok(eop_ok), .eop_inv(eop_inv), .link_fail(link_fail),
    .rx_raw(rx_raw), .rx_fixed(rx_fixed), .pol_bad(pol_bad)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lp_ok = 0; lp_inv = 0; eop_ok = 0; eop_inv = 0; link_fail = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One cycle of strobes: drive on a falling edge, release on the next one.
  task automatic strobe(input logic li, input logic lo, input logic ei,
                        input logic eo, input logic fl);
    @(negedge clk);
    lp_inv = li; lp_ok = lo; eop_inv = ei; eop_ok = eo; link_fail = fl;
    @(negedge clk);
    lp_inv = 0; lp_ok = 0; eop_inv = 0; eop_ok = 0; link_fail = 0;
  endtask

  task automatic lp_bad_n(input int n);
    for (int i = 0; i < n; i++) strobe(1, 0, 0, 0, 0);
  endtask

  task automatic eop_bad_n(input int n);
    for (int i = 0; i < n; i++) strobe(0, 0, 1, 0, 0);
  endtask

  task automatic check_data(input string req, input logic bad);
    for (int v = 0; v < 2; v++) begin
      rx_raw = v[0];
      #1;
      check(req, rx_fixed, v[0] ^ bad);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 pol_bad after reset", pol_bad, 1'b0);
    check_data("R1 data passes", 1'b0);

    // R2 / R8: unbroken link-pulse runs of every length
    for (int n = 0; n <= LINK_RUN + 3; n++) begin
      do_reset();
      lp_bad_n(n);
      check("R2 link run", pol_bad, logic'(n >= LINK_RUN));
      check_data("R8 data fix", logic'(n >= LINK_RUN));
    end

    // R3: unbroken packet-ending runs
    for (int n = 0; n <= EOP_RUN + 3; n++) begin
      do_reset();
      eop_bad_n(n);
      check("R3 eop run", pol_bad, logic'(n >= EOP_RUN));
    end

    // R4: a correct link pulse at each position restarts the run
    for (int b = 0; b < LINK_RUN; b++) begin
      do_reset();
      lp_bad_n(b);
      strobe(0, 1, 0, 0, 0);
      lp_bad_n(LINK_RUN - 1);
      check("R4 restart short", pol_bad, 1'b0);
      lp_bad_n(1);
      check("R4 restart full", pol_bad, 1'b1);
    end
    // R4: both signs together, correct sign wins
    do_reset();
    lp_bad_n(LINK_RUN - 1);
    strobe(1, 1, 0, 0, 0);
    check("R4 tie no set", pol_bad, 1'b0);
    lp_bad_n(LINK_RUN - 1);
    check("R4 tie restarted", pol_bad, 1'b0);

    // R5: a correct packet ending at each position restarts the run
    for (int b = 0; b < EOP_RUN; b++) begin
      do_reset();
      eop_bad_n(b);
      strobe(0, 0, 0, 1, 0);
      eop_bad_n(EOP_RUN - 1);
      check("R5 restart short", pol_bad, 1'b0);
      eop_bad_n(1);
      check("R5 restart full", pol_bad, 1'b1);
    end

    // R6: link traffic inside a packet-ending run
    do_reset();
    eop_bad_n(EOP_RUN - 1);
    lp_bad_n(LINK_RUN - 1);
    strobe(0, 1, 0, 0, 0);
    check("R6 link leaves eop", pol_bad, 1'b0);
    eop_bad_n(1);
    check("R6 eop run kept", pol_bad, 1'b1);
    // R6: packet-ending traffic inside a link run
    do_reset();
    lp_bad_n(LINK_RUN - 1);
    strobe(0, 0, 0, 1, 0);
    eop_bad_n(EOP_RUN - 1);
    check("R6 eop leaves link", pol_bad, 1'b0);
    lp_bad_n(1);
    check("R6 link run kept", pol_bad, 1'b1);

    // R7: latched through correct-sign traffic
    for (int k = 0; k < 6; k++) strobe(0, 1, 0, 1, 0);
    check("R7 flag held", pol_bad, 1'b1);
    check_data("R7 data still fixed", 1'b1);

    // R9: failure clears; same-cycle failure overrides set
    strobe(0, 0, 0, 0, 1);
    check("R9 fail clears", pol_bad, 1'b0);
    do_reset();
    lp_bad_n(LINK_RUN - 1);
    strobe(1, 0, 0, 0, 1);
    check("R9 fail beats set", pol_bad, 1'b0);
    lp_bad_n(1);
    check("R9 runs kept", pol_bad, 1'b1);

    // R10: long runs saturate, one more strobe re-sets after failure
    for (int n = LINK_RUN; n <= 3 * LINK_RUN; n += 3) begin
      do_reset();
      lp_bad_n(n);
      strobe(0, 0, 0, 0, 1);
      check("R10 link cleared", pol_bad, 1'b0);
      lp_bad_n(1);
      check("R10 link saturated", pol_bad, 1'b1);
    end
    for (int n = EOP_RUN; n <= 4 * EOP_RUN; n += 2) begin
      do_reset();
      eop_bad_n(n);
      strobe(0, 0, 0, 0, 1);
      eop_bad_n(1);
      check("R10 eop saturated", pol_bad, 1'b1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule